// File: doc/BRIEF.md
# Power-Down Mode Controller

This block manages the low-power states of a processor subsystem. A one-cycle strobe from the CPU, raised when a sleep instruction executes, asks the block to leave normal operation. A standby-select bit in a control register picks the target state. In light sleep only the CPU clock stops. In deep standby the oscillator is asked to stop, every clock domain is halted, and register contents are kept. The block drives clock enables for the CPU core, the bus interface and the peripheral group. It also drives an oscillator stop request and the pin treatment during standby: either hold the current level or go to high impedance.

A second control register holds one stop bit per peripheral. These bits gate each peripheral's clock on their own, whatever the global mode is. The block watches the wake-up sources, and each low-power state accepts only its own set of them. After a standby wake-up it waits a programmable number of cycles for the oscillator to settle before the CPU clock comes back. The power-on reset (asynchronous, released synchronously) and the synchronous manual reset both return the block to run mode at once.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, cpu_clk_en, bus_clk_en and per_clk_en are 1, every mod_clk_en bit is 1, and osc_stop, pin_hold and pin_hiz are 0.
- R2: A sleep_req in run mode while control bit 7 (standby select, register at rd_sel=0) is 0 enters sleep. From the next cycle cpu_clk_en is 0, bus_clk_en and per_clk_en stay 1, and osc_stop stays 0.
- R3: In sleep, any of irq, nmi or dma_err returns the block to run mode, with cpu_clk_en 1 in the next cycle.
- R4: A sleep_req in run mode while control bit 7 is 1 enters standby. From the next cycle osc_stop is 1 and cpu_clk_en, bus_clk_en and per_clk_en are 0. Both registers keep their contents through standby.
- R5: In standby, irq and dma_err have no effect. Only nmi or a reset ends it.
- R6: During standby and settling, pin_hiz is 1 when control bit 6 is 1, and pin_hold is 1 when that bit is 0. Both are 0 in run and sleep.
- R7: nmi in standby clears osc_stop in the next cycle. cpu_clk_en then stays 0 for (code+1)*SETTLE_UNIT cycles, counted from that cycle, where code is control bits 2:0. After that the block is in run mode.
- R8: Stop bit i (register at rd_sel=1, bit i) set to 1 forces mod_clk_en[i] to 0 and mod_pin_init[i] to 1 from the cycle after the write. Other modules are unaffected, and clearing the bit restores the clock.
- R9: Every mod_clk_en bit is also 0 while per_clk_en is 0 (standby and settling).
- R10: mrst, in any state, returns the block to run mode and clears both registers. Its effect is visible in the next cycle.
- R11: A sleep_req is ignored, and the block stays in run mode, when a wake-up event that qualifies for the selected target state is present in the same cycle (irq, nmi or dma_err for sleep; nmi only for standby).
- R12: A write (wr_en, wr_sel picks the register) is visible on rd_data, which is combinational from rd_sel, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 module stop |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 control, 1 module stop |
| rd_data | output | 8 | Read data |
| sleep_req | input | 1 | Sleep-instruction strobe from CPU |
| irq | input | 1 | Maskable interrupt pending |
| nmi | input | 1 | Non-maskable interrupt |
| dma_err | input | 1 | DMA address error |
| cpu_clk_en | output | 1 | CPU and cache clock enable |
| bus_clk_en | output | 1 | Bus interface clock enable |
| per_clk_en | output | 1 | Peripheral group clock enable |
| mod_clk_en | output | N_MOD | Per-peripheral clock enable |
| mod_pin_init | output | N_MOD | Per-peripheral pin initialise request |
| osc_stop | output | 1 | Oscillator stop request |
| pin_hold | output | 1 | Hold pins at current level |
| pin_hiz | output | 1 | Put pins in high impedance |

## Verification
The bench builds the block with N_MOD=8, so all eight stop bits line up with the full register byte. It uses SETTLE_UNIT=2, which keeps the longest settle window at 16 cycles. With these values the settle length can be measured cycle by cycle for both a short code and a long one. The same build runs the stop-bit patterns from a table, and then the wake-up filtering of each low-power state and the veto of a sleep strobe.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_STBY   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  localparam int REG_W          = 8;
  localparam int CTL_STBY_BIT   = 7;
  localparam int CTL_HIZ_BIT    = 6;
  localparam int CTL_SETTLE_LSB = 0;
  localparam int CTL_SETTLE_W   = 3;
endpackage

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
  import pwrdn_pkg::*;
#(
  parameter int N_MOD = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mrst,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 rd_sel,
  output logic [REG_W-1:0]     rd_data,
  output logic [REG_W-1:0]     ctrl_q,
  output logic [N_MOD-1:0]     stop_q
);
  logic [REG_W-1:0] ctrl_d;
  logic [N_MOD-1:0] stop_d;

  always_comb begin
    ctrl_d = ctrl_q;
    stop_d = stop_q;
    if (mrst) begin
      ctrl_d = '0;
      stop_d = '0;
    end else if (wr_en) begin
      if (wr_sel) stop_d = wr_data[N_MOD-1:0];
      else        ctrl_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stop_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stop_q <= stop_d;
    end
  end

  assign rd_data = rd_sel ? REG_W'(stop_q) : ctrl_q;
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
#(
  parameter int SETTLE_UNIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mrst,
  input  logic                    sleep_req,
  input  logic                    stby_sel,
  input  logic [CTL_SETTLE_W-1:0] settle_code,
  input  logic                    irq,
  input  logic                    nmi,
  input  logic                    dma_err,
  output pm_state_e               state_q
);
  localparam int MAX_LEN = (1 << CTL_SETTLE_W) * SETTLE_UNIT;
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  pm_state_e        state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wake_sleep, wake_stby;

  assign wake_sleep = irq | nmi | dma_err;
  assign wake_stby  = nmi;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (mrst) begin
      state_d = PM_RUN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (sleep_req) begin
            if (stby_sel) begin
              if (!wake_stby) state_d = PM_STBY;
            end else if (!wake_sleep) begin
              state_d = PM_SLEEP;
            end
          end
        end
        PM_SLEEP: begin
          if (wake_sleep) state_d = PM_RUN;
        end
        PM_STBY: begin
          if (wake_stby) begin
            state_d = PM_SETTLE;
            cnt_d   = CNT_W'((int'(settle_code) + 1) * SETTLE_UNIT - 1);
          end
        end
        PM_SETTLE: begin
          if (cnt_q == '0) state_d = PM_RUN;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/pwrdn_gate.sv
module pwrdn_gate
  import pwrdn_pkg::*;
#(
  parameter int N_MOD = 8
) (
  input  pm_state_e        state_q,
  input  logic             hiz_sel,
  input  logic [N_MOD-1:0] stop_q,
  output logic             cpu_clk_en,
  output logic             bus_clk_en,
  output logic             per_clk_en,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_pin_init,
  output logic             osc_stop,
  output logic             pin_hold,
  output logic             pin_hiz
);
  logic pins_parked;

  always_comb begin
    cpu_clk_en  = (state_q == PM_RUN);
    bus_clk_en  = (state_q == PM_RUN) || (state_q == PM_SLEEP);
    per_clk_en  = bus_clk_en;
    osc_stop    = (state_q == PM_STBY);
    pins_parked = (state_q == PM_STBY) || (state_q == PM_SETTLE);
    pin_hiz     = pins_parked & hiz_sel;
    pin_hold    = pins_parked & ~hiz_sel;
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    assign mod_clk_en[i]   = per_clk_en & ~stop_q[i];
    assign mod_pin_init[i] = stop_q[i];
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int N_MOD       = 8,
  parameter int SETTLE_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  input  logic             sleep_req,
  input  logic             irq,
  input  logic             nmi,
  input  logic             dma_err,
  output logic             cpu_clk_en,
  output logic             bus_clk_en,
  output logic             per_clk_en,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_pin_init,
  output logic             osc_stop,
  output logic             pin_hold,
  output logic             pin_hiz
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [7:0]       ctrl_q;
  logic [N_MOD-1:0] stop_q;
  pm_state_e        state_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwrdn_regs #(.N_MOD(N_MOD)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mrst    (mrst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_q),
    .stop_q  (stop_q)
  );

  pwrdn_fsm #(.SETTLE_UNIT(SETTLE_UNIT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mrst        (mrst),
    .sleep_req   (sleep_req),
    .stby_sel    (ctrl_q[CTL_STBY_BIT]),
    .settle_code (ctrl_q[CTL_SETTLE_LSB +: CTL_SETTLE_W]),
    .irq         (irq),
    .nmi         (nmi),
    .dma_err     (dma_err),
    .state_q     (state_q)
  );

  pwrdn_gate #(.N_MOD(N_MOD)) u_gate (
    .state_q      (state_q),
    .hiz_sel      (ctrl_q[CTL_HIZ_BIT]),
    .stop_q       (stop_q),
    .cpu_clk_en   (cpu_clk_en),
    .bus_clk_en   (bus_clk_en),
    .per_clk_en   (per_clk_en),
    .mod_clk_en   (mod_clk_en),
    .mod_pin_init (mod_pin_init),
    .osc_stop     (osc_stop),
    .pin_hold     (pin_hold),
    .pin_hiz      (pin_hiz)
  );
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
  parameter int N_MOD = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic             sleep_req,
  input logic             irq,
  input logic             nmi,
  input logic             dma_err,
  input logic             stby_sel,
  input logic [7:0]       ctrl_q,
  input logic             cpu_clk_en,
  input logic             bus_clk_en,
  input logic             per_clk_en,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic             osc_stop,
  input logic             pin_hold,
  input logic             pin_hiz
);
  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && !stby_sel && !irq && !nmi && !dma_err && !mrst)
    |=> (!cpu_clk_en && bus_clk_en && per_clk_en && !osc_stop));

  assert_sleep_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && bus_clk_en && (irq || nmi || dma_err)) |=> cpu_clk_en);

  assert_stby_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && stby_sel && !nmi && !mrst)
    |=> (osc_stop && !cpu_clk_en && !bus_clk_en && !per_clk_en));

  assert_stby_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !nmi && !mrst) |=> osc_stop);

  assert_pin_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pin_hold, pin_hiz}) && ((pin_hold || pin_hiz) -> !bus_clk_en));

  assert_settle_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && nmi && !mrst) |=> (!osc_stop && !cpu_clk_en));

  assert_modstop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && per_clk_en && !sleep_req && !mrst)
    |=> (mod_clk_en == ~$past(wr_data[N_MOD-1:0])));

  assert_mod_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_clk_en) |-> (mod_clk_en == '0));

  assert_mrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (cpu_clk_en && (&mod_clk_en) && (ctrl_q == 8'h00)));

  assert_sleep_veto_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && nmi) |=> cpu_clk_en);
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.N_MOD(N_MOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .mrst       (mrst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .sleep_req  (sleep_req),
  .irq        (irq),
  .nmi        (nmi),
  .dma_err    (dma_err),
  .stby_sel   (ctrl_q[7]),
  .ctrl_q     (ctrl_q),
  .cpu_clk_en (cpu_clk_en),
  .bus_clk_en (bus_clk_en),
  .per_clk_en (per_clk_en),
  .mod_clk_en (mod_clk_en),
  .osc_stop   (osc_stop),
  .pin_hold   (pin_hold),
  .pin_hiz    (pin_hiz)
);

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int N_MOD       = 8;
  localparam int SETTLE_UNIT = 2;

  // {stop pattern, expected mod_clk_en}
  localparam logic [15:0] STOP_VEC [6] = '{
    16'h01FE, 16'h807F, 16'hA55A, 16'hFF00, 16'h3CC3, 16'h00FF
  };

  logic clk = 1'b0;
  logic rst_n, mrst, wr_en, wr_sel, rd_sel, sleep_req, irq, nmi, dma_err;
  logic [7:0] wr_data, rd_data;
  logic cpu_clk_en, bus_clk_en, per_clk_en, osc_stop, pin_hold, pin_hiz;
  logic [N_MOD-1:0] mod_clk_en, mod_pin_init;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_ctrl #(.N_MOD(N_MOD), .SETTLE_UNIT(SETTLE_UNIT)) u_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .sleep_req(sleep_req),
    .irq(irq), .nmi(nmi), .dma_err(dma_err), .cpu_clk_en(cpu_clk_en),
    .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en), .mod_clk_en(mod_clk_en),
    .mod_pin_init(mod_pin_init), .osc_stop(osc_stop), .pin_hold(pin_hold),
    .pin_hiz(pin_hiz)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, string req, logic [7:0] exp);
    rd_sel = sel;
    #1;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mrst = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_sel = 1'b0; sleep_req = 1'b0; irq = 1'b0; nmi = 1'b0; dma_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    rd(1'b0, "R1 ctrl", 8'h00);
    rd(1'b1, "R1 stop", 8'h00);
    chk("R1 clk enables", {cpu_clk_en, bus_clk_en, per_clk_en}, 3'b111);
    chk("R1 mod_clk_en", 32'(mod_clk_en), 32'hFF);
    chk("R1 osc/pins", {osc_stop, pin_hold, pin_hiz}, 3'b000);

    // R8 / R12 table of stop patterns
    foreach (STOP_VEC[i]) begin
      wr(1'b1, STOP_VEC[i][15:8]);
      chk("R8 mod_clk_en", 32'(mod_clk_en), 32'(STOP_VEC[i][7:0]));
      chk("R8 mod_pin_init", 32'(mod_pin_init), 32'(STOP_VEC[i][15:8]));
      rd(1'b1, "R12 stop readback", STOP_VEC[i][15:8]);
    end

    // R2 sleep entry, R3 wake by dma_err
    wr(1'b0, 8'h00);
    pulse_sleep();
    chk("R2 sleep enables", {cpu_clk_en, bus_clk_en, per_clk_en, osc_stop}, 4'b0110);
    tick();
    chk("R2 sleep held", 32'(cpu_clk_en), 0);
    dma_err = 1'b1; tick(); dma_err = 1'b0;
    chk("R3 wake dma_err", 32'(cpu_clk_en), 1);
    // R3 wake by irq
    pulse_sleep();
    chk("R2 sleep again", 32'(cpu_clk_en), 0);
    irq = 1'b1; tick(); irq = 1'b0;
    chk("R3 wake irq", 32'(cpu_clk_en), 1);

    // R11 veto in sleep target
    irq = 1'b1; sleep_req = 1'b1; tick(); irq = 1'b0; sleep_req = 1'b0;
    chk("R11 sleep vetoed by irq", 32'(cpu_clk_en), 1);
    tick();
    chk("R11 still run", 32'(cpu_clk_en), 1);

    // R4 standby entry with hold pins, code 3
    wr(1'b0, 8'h83);
    wr(1'b1, 8'h05);
    pulse_sleep();
    chk("R4 standby enables", {osc_stop, cpu_clk_en, bus_clk_en, per_clk_en}, 4'b1000);
    chk("R6 hold pins", {pin_hold, pin_hiz}, 2'b10);
    chk("R9 mod gated", 32'(mod_clk_en), 0);
    // R5 irq and dma_err ignored
    irq = 1'b1; tick(); irq = 1'b0;
    chk("R5 irq ignored", 32'(osc_stop), 1);
    dma_err = 1'b1; tick(); dma_err = 1'b0;
    chk("R5 dma_err ignored", 32'(osc_stop), 1);
    chk("R5 cpu still off", 32'(cpu_clk_en), 0);
    rd(1'b0, "R4 ctrl kept", 8'h83);
    rd(1'b1, "R4 stop kept", 8'h05);
    // R7 settle (3+1)*2 = 8 cycles
    nmi = 1'b1; tick(); nmi = 1'b0;
    chk("R7 osc restarts", {osc_stop, cpu_clk_en}, 2'b00);
    repeat (7) tick();
    chk("R7 cpu off at end of window", 32'(cpu_clk_en), 0);
    chk("R6 pins held while settling", {pin_hold, pin_hiz}, 2'b10);
    tick();
    chk("R7 cpu back", 32'(cpu_clk_en), 1);
    chk("R8 stop bits after wake", 32'(mod_clk_en), 32'hFA);

    // R6 hiz pins, code 0 -> 2 cycles
    wr(1'b0, 8'hC0);
    pulse_sleep();
    chk("R6 hiz pins", {pin_hold, pin_hiz}, 2'b01);
    nmi = 1'b1; tick(); nmi = 1'b0;
    tick();
    chk("R7 short window", 32'(cpu_clk_en), 0);
    tick();
    chk("R7 short window end", 32'(cpu_clk_en), 1);
    chk("R6 pins released", {pin_hold, pin_hiz}, 2'b00);

    // R11 irq does not veto a standby strobe; R10 manual reset ends standby
    wr(1'b0, 8'h80);
    irq = 1'b1; sleep_req = 1'b1; tick(); irq = 1'b0; sleep_req = 1'b0;
    chk("R11 irq not a standby wake", 32'(osc_stop), 1);
    mrst = 1'b1; tick(); mrst = 1'b0;
    chk("R10 run after mrst", {cpu_clk_en, osc_stop}, 2'b10);
    chk("R10 mod clocks", 32'(mod_clk_en), 32'hFF);
    rd(1'b0, "R10 ctrl cleared", 8'h00);
    rd(1'b1, "R10 stop cleared", 8'h00);

    // R11 nmi vetoes standby strobe
    wr(1'b0, 8'h80);
    nmi = 1'b1; sleep_req = 1'b1; tick(); nmi = 1'b0; sleep_req = 1'b0;
    chk("R11 nmi vetoes standby", {cpu_clk_en, osc_stop}, 2'b10);

    // R10 manual reset from sleep
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h0F);
    pulse_sleep();
    chk("R2 sleep before mrst", 32'(cpu_clk_en), 0);
    mrst = 1'b1; tick(); mrst = 1'b0;
    chk("R10 sleep to run", 32'(cpu_clk_en), 1);
    chk("R10 stop bits cleared", 32'(mod_pin_init), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule